// File: doc/BRIEF.md
# Enable-Gated I2C Configuration Register Target

This block is an I2C-compatible target that gives a bus master access to a small bank of 8-bit configuration registers. It oversamples SCL and SDA with the system clock, recognises start, repeated start and stop conditions, and answers only to the fixed 7-bit address 1001000. A write sends a register pointer byte and then one data byte. A read is a write that sets the pointer, followed by a repeated start and the address with the read bit set. The target then shifts out the addressed register.

An active-low enable input gates every part of bus participation. Several identical devices with the same fixed address can therefore share one bus, as long as the master lowers only one enable at a time. The pointer is kept between transactions, so a later read uses the value set earlier. SDA is open-drain: the block asserts `sda_oe` to pull the line low and otherwise leaves it to the external pull-up. The register contents are presented in parallel on `cfg_o`, where they drive the functions that the block configures.

Top module: `i2c_cfg_target`

## Requirements
- R1: With enable low, a byte after a start whose upper seven bits equal 1001000 is acknowledged: SDA is held low for the whole ninth SCL clock. Bit 0 of that byte selects the direction, 0 for write and 1 for read.
- R2: While `en_n` is high, `sda_oe` is low from the next system clock on. If `en_n` rises during a transfer, the transfer is abandoned, no register changes, and the block stays idle until the next start.
- R3: A start or repeated start (SDA falling while SCL is high) restarts address reception at any point of a transfer. A repeated start followed by a write address begins a new pointer byte.
- R4: A byte whose upper seven bits differ from 1001000 is not acknowledged (SDA stays released). Every later byte up to the next start is also ignored and not acknowledged.
- R5: In a write, the first byte after the address is loaded into the pointer and the second byte into the register that the pointer selects. Both bytes are acknowledged, and the register output `cfg_o[8*p +: 8]` takes the new value.
- R6: The pointer persists across stop and start. After the read address is acknowledged, the selected register is shifted out MSB first, with each bit placed on SDA while SCL is low.
- R7: During a read, the master's bit in the ninth clock is sampled. On an ACK (0), the same register is sent again and the pointer is unchanged. On a NACK (1), SDA is released until the next start or stop.
- R8: Pointer values of NUM_REGS or above are still acknowledged. Data written to them changes no register, and reads from them return 0x00.
- R9: A stop (SDA rising while SCL is high) returns the block to idle. A third byte in a write transaction is not acknowledged and is not stored.
- R10: With enable held low, `sda_oe` changes only while SCL is low.
- R11: After reset, all registers read 0x00 on `cfg_o` and `sda_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_n | input | 1 | Active-low module enable, synchronous to clk |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level as seen on the wired bus |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_o | output | 8*NUM_REGS | All register contents, register p at bits 8p+7..8p |

## Verification
The assertions rely on bus behaviour that any real bus shows. SDA changes only while SCL is low, except when the master makes a start or a stop. The master never makes a stop or a start while the target is pulling SDA low. The enable input changes synchronously to the system clock. The bench's bus model keeps to these rules by construction: it derives the line as the wired AND of the master and `sda_oe`, moves data only in the low quarter of each SCL period, uses quarter periods of ten system clocks, and changes enable only between bit slots.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK,
        ST_WAIT
    } state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_PTR,
        PH_DATA
    } phase_e;

    typedef struct packed {
        state_e             st;
        phase_e             ph;
        logic               rw;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  sh;
        logic [BYTE_W-1:0]  ptr;
        logic               drive;
    } fsm_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.scl_pipe = {s_q.scl_pipe[STAGES-2:0], scl_i};
        s_d.sda_pipe = {s_q.sda_pipe[STAGES-2:0], sda_i};
        s_d.scl_p    = s_q.scl_pipe[STAGES-1];
        s_d.sda_p    = s_q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_s     = s_q.scl_pipe[STAGES-1];
    assign sda_s     = s_q.sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~s_q.scl_p;
    assign scl_fall  = ~scl_s & s_q.scl_p;
    assign start_det = scl_s & s_q.scl_p & s_q.sda_p & ~sda_s;
    assign stop_det  = scl_s & s_q.scl_p & ~s_q.sda_p & sda_s;
endmodule

// File: rtl/i2c_cfg_regbank.sv
module i2c_cfg_regbank
    import i2c_cfg_pkg::*;
#(
    parameter int NUM_REGS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [BYTE_W-1:0]          ptr,
    input  logic [BYTE_W-1:0]          wdata,
    output logic [BYTE_W-1:0]          rdata,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);
    localparam int              IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [BYTE_W:0] LIMIT = (BYTE_W+1)'(NUM_REGS);

    logic [BYTE_W-1:0] regs_d [NUM_REGS];
    logic [BYTE_W-1:0] regs_q [NUM_REGS];
    logic              in_range;
    logic [IDX_W-1:0]  idx;

    assign in_range = {1'b0, ptr} < LIMIT;
    assign idx      = ptr[IDX_W-1:0];

    always_comb begin
        regs_d = regs_q;
        if (we && in_range) regs_d[idx] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rdata = in_range ? regs_q[idx] : '0;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
        assign cfg_o[g*BYTE_W +: BYTE_W] = regs_q[g];
    end

    a_r8_oob_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !in_range) |=> $stable(cfg_o));
    a_r5_no_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg_o));
endmodule

// File: rtl/i2c_cfg_fsm.sv
module i2c_cfg_fsm
    import i2c_cfg_pkg::*;
#(
    parameter logic [6:0] TARGET_ADDR = 7'b1001000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rdata,
    output logic              we,
    output logic [BYTE_W-1:0] ptr,
    output logic [BYTE_W-1:0] wdata,
    output logic              sda_oe
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    fsm_t q, d;

    always_comb begin
        d  = q;
        we = 1'b0;
        if (en_n) begin
            d.st    = ST_IDLE;
            d.drive = 1'b0;
            d.cnt   = '0;
        end else if (start_det) begin
            d.st    = ST_RX;
            d.ph    = PH_ADDR;
            d.cnt   = '0;
            d.drive = 1'b0;
        end else if (stop_det) begin
            d.st    = ST_IDLE;
            d.drive = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise && q.cnt < FULL) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == FULL) begin
                        d.st    = ST_ACK;
                        d.drive = 1'b1;
                        case (q.ph)
                            PH_ADDR: begin
                                if (q.sh[BYTE_W-1:1] == TARGET_ADDR) begin
                                    d.rw = q.sh[0];
                                end else begin
                                    d.st    = ST_WAIT;
                                    d.drive = 1'b0;
                                end
                            end
                            PH_PTR:  d.ptr = q.sh;
                            default: we = 1'b1;
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.drive = 1'b0;
                        d.cnt   = '0;
                        if (q.ph == PH_ADDR && q.rw) begin
                            d.st    = ST_TX;
                            d.sh    = rdata;
                            d.drive = ~rdata[BYTE_W-1];
                        end else if (q.ph == PH_ADDR) begin
                            d.st = ST_RX;
                            d.ph = PH_PTR;
                        end else if (q.ph == PH_PTR) begin
                            d.st = ST_RX;
                            d.ph = PH_DATA;
                        end else begin
                            d.st = ST_WAIT;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == LAST) begin
                            d.st    = ST_RACK;
                            d.drive = 1'b0;
                        end else begin
                            d.sh    = {q.sh[BYTE_W-2:0], 1'b0};
                            d.cnt   = q.cnt + 1'b1;
                            d.drive = ~q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise && sda_s) begin
                        d.st = ST_WAIT;
                    end else if (scl_fall) begin
                        d.st    = ST_TX;
                        d.sh    = rdata;
                        d.cnt   = '0;
                        d.drive = ~rdata[BYTE_W-1];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.ph    <= PH_ADDR;
        end else begin
            q <= d;
        end
    end

    assign ptr    = q.ptr;
    assign wdata  = q.sh;
    assign sda_oe = q.drive;

    a_r3_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && start_det) |=> (q.st == ST_RX && q.ph == PH_ADDR && q.cnt == '0 && !sda_oe));
    a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && stop_det && !start_det) |=> (q.st == ST_IDLE && !sda_oe));
    a_r7_nack_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && !start_det && !stop_det && q.st == ST_RACK && scl_rise && sda_s)
        |=> (q.st == ST_WAIT && !sda_oe));
endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
    import i2c_cfg_pkg::*;
#(
    parameter int         NUM_REGS    = 4,
    parameter logic [6:0] TARGET_ADDR = 7'b1001000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe,
    output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              we;
    logic [BYTE_W-1:0] ptr, wdata, rdata;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_cfg_fsm #(.TARGET_ADDR(TARGET_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .rdata(rdata),
        .we(we), .ptr(ptr), .wdata(wdata), .sda_oe(sda_oe)
    );

    i2c_cfg_regbank #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(we), .ptr(ptr), .wdata(wdata),
        .rdata(rdata), .cfg_o(cfg_o)
    );

    a_r2_disabled_released: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> !sda_oe);
    a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(en_n) && sda_oe != $past(sda_oe)) |-> !$past(scl_s));
endmodule

// File: tb/i2c_cfg_target_test.sv
module i2c_cfg_target_test;
    localparam int NREG = 4;
    localparam int Q    = 10;

    logic clk = 1'b0, rst_n = 1'b0, en_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
    logic sda_line, sda_oe;
    logic [NREG*8-1:0] cfg;

    assign sda_line = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    i2c_cfg_target #(.NUM_REGS(NREG)) uut (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .cfg_o(cfg)
    );

    typedef struct { logic [7:0] val; string tag; } exp_t;
    exp_t expq[$];
    int   n_cmp = 0, n_bad = 0, viol = 0;
    logic [7:0] obs_val;
    event got;

    initial forever begin
        @got;
        n_cmp++;
        if (expq.size() == 0) begin
            n_bad++;
            $display("FAIL unexpected item: actual %h expected none", obs_val);
        end else begin
            exp_t e;
            e = expq.pop_front();
            if (obs_val !== e.val) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", e.tag, obs_val, e.val);
            end
        end
    end

    logic prev_oe = 1'b0, prev_en = 1'b1;
    always @(posedge clk) begin
        prev_oe <= sda_oe;
        prev_en <= en_n;
        if (rst_n && !en_n && !prev_en && sda_oe != prev_oe && scl_m) viol <= viol + 1;
    end

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    task automatic push(input logic [7:0] v, input string tag);
        exp_t e;
        e.val = v;
        e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic observe(input logic [7:0] v);
        obs_val = v;
        ->got;
        @(negedge clk);
    endtask

    task automatic wq;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] v, input logic exp_ack, input string tag);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        push({7'b0, exp_ack}, tag);
        recv_bit(a);
        observe({7'b0, a});
    endtask

    task automatic recv_byte(input logic [7:0] exp, input logic mack, input string tag);
        logic [7:0] v;
        push(exp, tag);
        for (int i = 7; i >= 0; i--) recv_bit(v[i]);
        observe(v);
        send_bit(mack);
    endtask

    task automatic check_reg(input int idx, input logic [7:0] exp, input string tag);
        push(exp, tag);
        observe(cfg[idx*8 +: 8]);
    endtask

    task automatic write_reg(input logic [7:0] p, input logic [7:0] v, input string tag);
        bus_start();
        send_byte(8'h90, 1'b0, {tag, " addr ack (R1)"});
        send_byte(p, 1'b0, {tag, " ptr ack"});
        send_byte(v, 1'b0, {tag, " data ack"});
        bus_stop();
    endtask

    initial begin
        logic b;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R11 reset state
        for (int i = 0; i < NREG; i++) check_reg(i, 8'h00, "R11 reset register");
        push(8'h00, "R11 sda released");
        observe({7'b0, sda_oe});

        // R1, R5 writes
        write_reg(8'h01, 8'hA5, "R5 write1");
        check_reg(1, 8'hA5, "R5 reg1 stored");
        write_reg(8'h02, 8'h3C, "R5 write2");
        check_reg(2, 8'h3C, "R5 reg2 stored");
        check_reg(1, 8'hA5, "R5 reg1 kept");

        // R6, R7 read with repeated start
        bus_start();
        send_byte(8'h90, 1'b0, "R6 addr w");
        send_byte(8'h01, 1'b0, "R6 ptr");
        bus_start();
        send_byte(8'h91, 1'b0, "R6 addr r ack");
        recv_byte(8'hA5, 1'b0, "R6 read data");
        recv_byte(8'hA5, 1'b1, "R7 reread after master ack");
        push(8'h01, "R7 released after nack");
        recv_bit(b);
        observe({7'b0, b});
        bus_stop();

        // R6 pointer persists across stop
        bus_start();
        send_byte(8'h91, 1'b0, "R6 addr r persist");
        recv_byte(8'hA5, 1'b1, "R6 pointer persists");
        bus_stop();

        // R4 address mismatch
        bus_start();
        send_byte(8'h92, 1'b1, "R4 wrong addr nack");
        send_byte(8'h01, 1'b1, "R4 later byte nack");
        send_byte(8'h77, 1'b1, "R4 later byte2 nack");
        bus_stop();
        check_reg(1, 8'hA5, "R4 reg1 unchanged");

        // R8 out of range pointer
        write_reg(8'h07, 8'hFF, "R8 oob write");
        for (int i = 0; i < NREG; i++)
            check_reg(i, (i == 1) ? 8'hA5 : ((i == 2) ? 8'h3C : 8'h00), "R8 no register changed");
        bus_start();
        send_byte(8'h91, 1'b0, "R8 addr r");
        recv_byte(8'h00, 1'b1, "R8 oob read zero");
        bus_stop();

        // R9 third byte ignored
        bus_start();
        send_byte(8'h90, 1'b0, "R9 addr");
        send_byte(8'h02, 1'b0, "R9 ptr");
        send_byte(8'h11, 1'b0, "R9 data");
        send_byte(8'h22, 1'b1, "R9 extra byte nack");
        bus_stop();
        check_reg(2, 8'h11, "R9 first data kept");

        // R2 disabled device
        en_n = 1'b1;
        bus_start();
        send_byte(8'h90, 1'b1, "R2 disabled addr nack");
        send_byte(8'h00, 1'b1, "R2 disabled ptr nack");
        send_byte(8'h55, 1'b1, "R2 disabled data nack");
        bus_stop();
        check_reg(0, 8'h00, "R2 disabled write ignored");
        en_n = 1'b0;
        bus_start();
        send_byte(8'h90, 1'b0, "R2 addr");
        send_byte(8'h00, 1'b0, "R2 ptr");
        en_n = 1'b1;
        send_byte(8'h66, 1'b1, "R2 aborted data nack");
        en_n = 1'b0;
        send_byte(8'h67, 1'b1, "R2 idle until start");
        bus_stop();
        check_reg(0, 8'h00, "R2 abort no change");

        // R3 repeated start inside a write
        bus_start();
        send_byte(8'h90, 1'b0, "R3 addr");
        send_byte(8'h03, 1'b0, "R3 ptr");
        bus_start();
        send_byte(8'h90, 1'b0, "R3 readdress");
        send_byte(8'h03, 1'b0, "R3 new ptr");
        send_byte(8'h5A, 1'b0, "R3 data");
        bus_stop();
        check_reg(3, 8'h5A, "R3 write after repeated start");

        // R10 SDA change only while SCL low
        push(8'h00, "R10 sda changes with scl high");
        observe(viol[7:0]);

        repeat (20) @(negedge clk);
        if (expq.size() != 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL pending items: actual %0d expected 0", expq.size());
        end
        summary();
        $finish;
    end
endmodule